// File: doc/BRIEF.md
# Streaming Frame Packer

The packer takes data words from a valid/ready stream, groups them into blocks marked by an end-of-block flag, and sends whole blocks out as frames on a second valid/ready stream. Each outgoing frame is marked with a start flag on its first word and an end flag on its last word. It also carries a 15-bit sequence number, which steps by one per frame.

A frame is started by one of four triggers. The first is a one-cycle flush pulse. The second is an idle timeout after the last accepted word. The third is the count of pending words going above a threshold. The fourth is the pending count reaching the per-frame word limit. Only words of complete blocks count as pending. A frame takes whole blocks from the oldest end while their total stays within the word limit, so a block is never split. A block that reaches the word limit without its end flag is closed by force.

Back-pressure on the input: a word transfers when `in_valid` and `in_ready` are both high at a clock edge. While idle, `in_ready` is high when the buffer has a free slot. While a frame is going out, `in_ready` is high only when the buffer can still take a full block. On the output, a word transfers when `out_valid` and `out_ready` are both high. While `out_ready` is low, the word on offer and its flags hold steady.

Top module: `fpk_frame_packer`

## Requirements
- R1: After reset `out_valid` is 0, `in_ready` is 1, nothing is pending, and the first frame carries sequence number 0.
- R2: Frame words leave in input order. `out_sof` is set on the first word and `out_eof` on the last word. While `out_ready` is low, `out_valid`, the data, the flags and the sequence number hold.
- R3: A flush pulse sampled in cycle f, with at least one complete block pending, puts the first frame word on the output in cycle f+1. A flush sampled while a frame is being sent is remembered until the next frame starts.
- R4: A flush while no complete block is pending produces no frame, even if an unfinished block is buffered.
- R5: An idle counter restarts on every accepted word and runs only while complete blocks are pending. If the last word is accepted at the edge ending cycle d, the frame's first word appears in cycle d+TIMEOUT+2.
- R6: When the pending count goes above THRESH, a frame starts at the next edge, and its first word appears two cycles after the closing word was driven.
- R7: A pending count of at least MAX_WORDS also starts a frame. A frame takes whole blocks from the head while their sum is at most MAX_WORDS, and the blocks left over go out in later frames.
- R8: A block that reaches MAX_WORDS words without its end flag is closed at that word. The words after it start a new block.
- R9: The sequence number steps by one after each frame's last word and wraps modulo 2^15.
- R10: `in_ready` is high when the block-length queue is not full and one of two conditions holds. While idle, at least one buffer slot must be free. While sending, at least MAX_WORDS slots must be free.
- R11: If several triggers are active together, exactly one frame starts, and the flush memory and idle counter are cleared at that start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word can be taken |
| in_data | input | W | Input data word |
| in_last | input | 1 | Word ends its block |
| flush_pulse | input | 1 | One-cycle request to send pending blocks |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Sink takes the output word |
| out_data | output | W | Output data word |
| out_sof | output | 1 | First word of a frame |
| out_eof | output | 1 | Last word of a frame |
| out_seq | output | SEQ_W | Sequence number of the current frame |

## Verification
A wrong pending count or block-length entry shows up as a wrong frame length. That appears at the first `out_eof` of the affected frame, or as a frame that starts one or more cycles away from the cycle its trigger predicts. A wrong idle counter or a stale flush memory moves the start of the next frame, which is visible at its `out_sof`. A wrong buffer count shows up in `in_ready` in the same cycle. The reference model compares every port on every clock, so each of these errors is reported in the cycle where it first reaches a port.

// File: rtl/fpk_pkg.sv
package fpk_pkg;
  typedef enum logic {
    FPK_IDLE = 1'b0,
    FPK_SEND = 1'b1
  } fpk_state_e;
endpackage

// File: rtl/fpk_word_fifo.sv
module fpk_word_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [W-1:0]               push_data,
  input  logic                       pop,
  output logic [W-1:0]               head_data,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
      count <= count + CW'(push) - CW'(pop);
    end
  end

  assign head_data = mem[rd_ptr];
endmodule

// File: rtl/fpk_len_queue.sv
module fpk_len_queue #(
  parameter int LW = 5,
  parameter int N  = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   push,
  input  logic [LW-1:0]          push_len,
  input  logic [$clog2(N+1)-1:0] pop_n,
  output logic [$clog2(N+1)-1:0] count,
  output logic [N-1:0][LW-1:0]   peek
);
  localparam int PW = $clog2(N);
  localparam int NW = $clog2(N+1);

  logic [LW-1:0] mem [N];
  logic [PW-1:0] wr_ptr, rd_ptr, rd_next;
  int            rd_sum;
  int            idx;

  always_comb begin
    rd_sum = int'(rd_ptr) + int'(pop_n);
    if (rd_sum >= N) rd_sum = rd_sum - N;
    rd_next = PW'(rd_sum);
  end

  always_comb begin
    idx = 0;
    for (int i = 0; i < N; i++) begin
      idx = int'(rd_ptr) + i;
      if (idx >= N) idx = idx - N;
      peek[i] = mem[PW'(idx)];
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_len;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == PW'(N-1)) ? '0 : wr_ptr + 1'b1;
      rd_ptr <= rd_next;
      count  <= count + NW'(push) - pop_n;
    end
  end
endmodule

// File: rtl/fpk_sizer.sv
module fpk_sizer #(
  parameter int LW        = 5,
  parameter int N         = 8,
  parameter int CW        = 6,
  parameter int MAX_WORDS = 16
) (
  input  logic [N-1:0][LW-1:0]   peek,
  input  logic [$clog2(N+1)-1:0] count,
  output logic [CW-1:0]          frame_len,
  output logic [$clog2(N+1)-1:0] nblk
);
  localparam int NW = $clog2(N+1);
  localparam int SW = $clog2(2*MAX_WORDS+1);

  logic [SW-1:0] acc;
  logic [NW-1:0] nb;
  logic          stop;

  always_comb begin
    acc  = '0;
    nb   = '0;
    stop = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (!stop && (NW'(i) < count) &&
          ((acc + SW'(peek[i])) <= SW'(MAX_WORDS))) begin
        acc = acc + SW'(peek[i]);
        nb  = nb + 1'b1;
      end else begin
        stop = 1'b1;
      end
    end
    frame_len = CW'(acc);
    nblk      = nb;
  end
endmodule

// File: rtl/fpk_trigger.sv
module fpk_trigger #(
  parameter int CW        = 6,
  parameter int TIMEOUT   = 20,
  parameter int THRESH    = 12,
  parameter int MAX_WORDS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          is_idle,
  input  logic          flush,
  input  logic          accept,
  input  logic [CW-1:0] pending,
  output logic          start
);
  localparam int TW = $clog2(TIMEOUT+1);

  logic [TW-1:0] idle_cnt;
  logic          flush_mem;
  logic          expired;
  logic          have_data;

  assign have_data = (pending != '0);
  assign expired   = (idle_cnt == TW'(TIMEOUT));
  assign start = is_idle && have_data &&
                 (flush || flush_mem || expired ||
                  (int'(pending) > THRESH) || (int'(pending) >= MAX_WORDS));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idle_cnt  <= '0;
      flush_mem <= 1'b0;
    end else begin
      if (start || accept || !have_data) idle_cnt <= '0;
      else if (!expired)                 idle_cnt <= idle_cnt + 1'b1;

      if (start)                      flush_mem <= 1'b0;
      else if (is_idle && !have_data) flush_mem <= 1'b0;
      else                            flush_mem <= flush_mem | flush;
    end
  end
endmodule

// File: rtl/fpk_frame_packer.sv
module fpk_frame_packer #(
  parameter int W          = 16,
  parameter int DEPTH      = 32,
  parameter int MAX_WORDS  = 16,
  parameter int THRESH     = 12,
  parameter int TIMEOUT    = 20,
  parameter int MAX_BLOCKS = 8,
  parameter int SEQ_W      = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [W-1:0]     in_data,
  input  logic             in_last,
  input  logic             flush_pulse,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [W-1:0]     out_data,
  output logic             out_sof,
  output logic             out_eof,
  output logic [SEQ_W-1:0] out_seq
);
  import fpk_pkg::*;

  localparam int CW = $clog2(DEPTH+1);
  localparam int LW = $clog2(MAX_WORDS+1);
  localparam int NW = $clog2(MAX_BLOCKS+1);

  fpk_state_e                 state;
  logic [CW-1:0]              fifo_cnt;
  logic [CW-1:0]              pending;
  logic [LW-1:0]              open_cnt, close_len;
  logic [CW-1:0]              flen, sent;
  logic [CW-1:0]              frame_len;
  logic [NW-1:0]              nblk, blk_cnt;
  logic [MAX_BLOCKS-1:0][LW-1:0] peek;
  logic [SEQ_W-1:0]           seq;
  logic                       accept, close, start, pop;
  int                         free_slots;

  assign free_slots = DEPTH - int'(fifo_cnt);
  assign in_ready   = (int'(blk_cnt) != MAX_BLOCKS) &&
                      ((state == FPK_IDLE) ? (free_slots >= 1)
                                           : (free_slots >= MAX_WORDS));
  assign accept     = in_valid && in_ready;
  assign close      = accept && (in_last || (open_cnt == LW'(MAX_WORDS-1)));
  assign close_len  = open_cnt + 1'b1;
  assign pop        = out_valid && out_ready;

  fpk_word_fifo #(.W(W), .DEPTH(DEPTH)) words_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (accept),
    .push_data (in_data),
    .pop       (pop),
    .head_data (out_data),
    .count     (fifo_cnt)
  );

  fpk_len_queue #(.LW(LW), .N(MAX_BLOCKS)) lens_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (close),
    .push_len (close_len),
    .pop_n    (start ? nblk : NW'(0)),
    .count    (blk_cnt),
    .peek     (peek)
  );

  fpk_sizer #(.LW(LW), .N(MAX_BLOCKS), .CW(CW), .MAX_WORDS(MAX_WORDS)) sizer_i (
    .peek      (peek),
    .count     (blk_cnt),
    .frame_len (frame_len),
    .nblk      (nblk)
  );

  fpk_trigger #(.CW(CW), .TIMEOUT(TIMEOUT), .THRESH(THRESH),
                .MAX_WORDS(MAX_WORDS)) trig_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .is_idle (state == FPK_IDLE),
    .flush   (flush_pulse),
    .accept  (accept),
    .pending (pending),
    .start   (start)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_cnt <= '0;
      pending  <= '0;
    end else begin
      if (accept) open_cnt <= close ? '0 : open_cnt + 1'b1;
      pending <= pending + (close ? CW'(close_len) : CW'(0))
                         - (start ? frame_len : CW'(0));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= FPK_IDLE;
      flen  <= '0;
      sent  <= '0;
      seq   <= '0;
    end else begin
      case (state)
        FPK_IDLE: if (start) begin
          state <= FPK_SEND;
          flen  <= frame_len;
          sent  <= '0;
        end
        FPK_SEND: if (pop) begin
          if (sent == flen - 1'b1) begin
            state <= FPK_IDLE;
            seq   <= seq + 1'b1;
          end else begin
            sent <= sent + 1'b1;
          end
        end
        default: state <= FPK_IDLE;
      endcase
    end
  end

  assign out_valid = (state == FPK_SEND);
  assign out_sof   = (sent == '0);
  assign out_eof   = (sent == flen - 1'b1);
  assign out_seq   = seq;
endmodule

// File: rtl/fpk_frame_packer_chk.sv
module fpk_frame_packer_chk #(
  parameter int W         = 16,
  parameter int DEPTH     = 32,
  parameter int MAX_WORDS = 16,
  parameter int SEQ_W     = 15
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       in_valid,
  input logic                       in_ready,
  input logic                       out_valid,
  input logic                       out_ready,
  input logic [W-1:0]               out_data,
  input logic                       out_sof,
  input logic                       out_eof,
  input logic [SEQ_W-1:0]           out_seq,
  input logic [$clog2(DEPTH+1)-1:0] fifo_cnt,
  input logic [$clog2(DEPTH+1)-1:0] pend,
  input logic                       start
);
  int wcnt;

  always_ff @(posedge clk) begin
    if (!rst_n) wcnt <= 0;
    else if (out_valid && out_ready) wcnt <= out_eof ? 0 : wcnt + 1;
  end

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) &&
      $stable(out_sof) && $stable(out_eof) && $stable(out_seq));

  assert_first_sof_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> out_sof);

  assert_seq_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_eof |=> out_seq == SEQ_W'($past(out_seq) + 1'b1));

  assert_frame_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> wcnt < MAX_WORDS);

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |-> int'(fifo_cnt) < DEPTH);

  assert_send_room_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && in_ready |-> (DEPTH - int'(fifo_cnt)) >= MAX_WORDS);

  assert_start_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> pend != '0);
endmodule

bind fpk_frame_packer fpk_frame_packer_chk #(
  .W(W), .DEPTH(DEPTH), .MAX_WORDS(MAX_WORDS), .SEQ_W(SEQ_W)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_sof   (out_sof),
  .out_eof   (out_eof),
  .out_seq   (out_seq),
  .fifo_cnt  (fifo_cnt),
  .pend      (pending),
  .start     (start)
);

// File: tb/fpk_frame_packer_tb_top.sv
module fpk_frame_packer_tb_top;
  localparam int W    = 16;
  localparam int DP   = 32;
  localparam int MAXW = 16;
  localparam int TH   = 12;
  localparam int TO   = 20;
  localparam int NB   = 8;
  localparam int SW   = 15;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0, in_ready, in_last = 1'b0, flush_pulse = 1'b0;
  logic [W-1:0]  in_data = '0;
  logic          out_valid, out_ready = 1'b1, out_sof, out_eof;
  logic [W-1:0]  out_data;
  logic [SW-1:0] out_seq;

  int total = 0, bad = 0, cyc = 0, ordy_mode = 0, last_drive = 0, wc = 0;
  int lens_q[$], sof_q[$], seq_q[$];

  // reference model state
  int m_state, m_flen, m_sent, m_seq, m_pend, m_open, m_idle, m_flag;
  logic [W-1:0] wq[$];
  int bq[$];

  always #5 clk = ~clk;

  fpk_frame_packer #(.W(W), .DEPTH(DP), .MAX_WORDS(MAXW), .THRESH(TH),
                     .TIMEOUT(TO), .MAX_BLOCKS(NB), .SEQ_W(SW)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .flush_pulse(flush_pulse),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sof(out_sof), .out_eof(out_eof), .out_seq(out_seq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic bit model_ready();
    int free;
    free = DP - wq.size();
    return (bq.size() != NB) && ((m_state == 0) ? (free >= 1) : (free >= MAXW));
  endfunction

  // monitor, reference model step, cycle count, watchdog
  always @(posedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (out_sof) begin
        sof_q.push_back(cyc);
        seq_q.push_back(int'(out_seq));
        wc = 0;
      end
      wc++;
      if (out_eof) lens_q.push_back(wc);
    end
    if (!rst_n) begin
      m_state = 0; m_flen = 0; m_sent = 0; m_seq = 0; m_pend = 0;
      m_open = 0; m_idle = 0; m_flag = 0;
      wq.delete(); bq.delete();
    end else begin
      bit acc, cls, st, pop, expd;
      int clen, s, nb;
      acc  = in_valid && model_ready();
      cls  = acc && (in_last || m_open == MAXW-1);
      clen = m_open + 1;
      expd = (m_idle == TO);
      st   = (m_state == 0) && (m_pend != 0) &&
             (flush_pulse || m_flag != 0 || expd || m_pend > TH || m_pend >= MAXW);
      s = 0; nb = 0;
      foreach (bq[i]) begin
        if (nb == i && s + bq[i] <= MAXW) begin s += bq[i]; nb++; end
      end
      pop = (m_state == 1) && out_ready;
      if (st) m_flag = 0;
      else if (m_state == 0 && m_pend == 0) m_flag = 0;
      else if (flush_pulse) m_flag = 1;
      if (st || acc || m_pend == 0) m_idle = 0;
      else if (!expd) m_idle++;
      if (pop) begin
        void'(wq.pop_front());
        if (m_sent == m_flen - 1) begin m_state = 0; m_seq = (m_seq + 1) % (1 << SW); end
        else m_sent++;
      end
      if (st) begin
        m_state = 1; m_flen = s; m_sent = 0; m_pend -= s;
        for (int k = 0; k < nb; k++) void'(bq.pop_front());
      end
      if (acc) begin
        wq.push_back(in_data);
        m_open = cls ? 0 : m_open + 1;
      end
      if (cls) begin bq.push_back(clen); m_pend += clen; end
    end
    cyc++;
    if (cyc > 100000) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // per-cycle port comparison and output back-pressure pattern
  always @(negedge clk) begin
    if (ordy_mode == 1) out_ready = (cyc % 3) != 0;
    else if (ordy_mode == 2) out_ready = 1'b0;
    else out_ready = 1'b1;
    if (rst_n) begin
      chk(in_ready == model_ready(), "R10 in_ready", int'(in_ready), int'(model_ready()));
      chk(out_valid == (m_state == 1), "R2 out_valid", int'(out_valid), int'(m_state == 1));
      if (out_valid && m_state == 1) begin
        chk(out_data == wq[0], "R2 out_data", int'(out_data), int'(wq[0]));
        chk(out_sof == (m_sent == 0), "R2 out_sof", int'(out_sof), int'(m_sent == 0));
        chk(out_eof == (m_sent == m_flen - 1), "R2 out_eof", int'(out_eof), int'(m_sent == m_flen - 1));
        chk(int'(out_seq) == m_seq, "R9 out_seq", int'(out_seq), m_seq);
      end
    end
  end

  // all tasks start and end at a falling edge
  task automatic send_word(input logic [W-1:0] d, input logic last);
    bit ok;
    in_valid = 1'b1; in_data = d; in_last = last;
    ok = 0;
    while (!ok) begin
      #1;
      ok = in_ready;
      if (ok) last_drive = cyc;
      @(negedge clk);
    end
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic send_block(input int n, input int base);
    for (int i = 0; i < n; i++) send_word(W'(base + i), i == n - 1);
  endtask

  task automatic pulse_flush(output int fc);
    fc = cyc;
    flush_pulse = 1'b1;
    @(negedge clk);
    flush_pulse = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int fc, n0, d;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    idle(1);
    chk(in_ready == 1'b1, "R1 reset in_ready", int'(in_ready), 1);
    chk(out_valid == 1'b0, "R1 reset out_valid", int'(out_valid), 0);

    // R3: flush starts a frame the next cycle
    send_block(3, 'h100);
    idle(3);
    pulse_flush(fc);
    idle(10);
    chk(lens_q.size() == 1, "R3 flush frame count", lens_q.size(), 1);
    chk(lens_q[0] == 3, "R3 flush frame length", lens_q[0], 3);
    chk(sof_q[0] == fc + 1, "R3 flush start cycle", sof_q[0], fc + 1);

    // R4: flush with nothing pending, then with only an open block
    n0 = lens_q.size();
    pulse_flush(fc);
    idle(30);
    chk(lens_q.size() == n0, "R4 empty flush", lens_q.size(), n0);
    send_word('h200, 1'b0);
    send_word('h201, 1'b0);
    pulse_flush(fc);
    idle(30);
    chk(lens_q.size() == n0, "R4 open block flush", lens_q.size(), n0);

    // R5: timeout after the closing word
    send_word('h202, 1'b1);
    d = last_drive;
    idle(40);
    chk(lens_q[$] == 3, "R5 timeout frame length", lens_q[$], 3);
    chk(sof_q[$] == d + TO + 2, "R5 timeout start cycle", sof_q[$], d + TO + 2);

    // R5: counter restarts on each accepted word
    send_block(2, 'h300);
    idle(10);
    send_block(3, 'h310);
    d = last_drive;
    idle(40);
    chk(lens_q[$] == 5, "R5 restart frame length", lens_q[$], 5);
    chk(sof_q[$] == d + TO + 2, "R5 restart start cycle", sof_q[$], d + TO + 2);

    // R6: threshold crossing
    send_block(5, 'h400);
    send_block(5, 'h410);
    send_block(4, 'h420);
    d = last_drive;
    idle(25);
    chk(lens_q[$] == 14, "R6 threshold frame length", lens_q[$], 14);
    chk(sof_q[$] == d + 2, "R6 threshold start cycle", sof_q[$], d + 2);

    // R7: whole blocks up to the word limit, rest in a later frame
    n0 = lens_q.size();
    send_block(6, 'h500);
    send_block(6, 'h510);
    send_block(6, 'h520);
    idle(50);
    chk(lens_q.size() == n0 + 2, "R7 frame count", lens_q.size(), n0 + 2);
    chk(lens_q[n0] == 12, "R7 first frame length", lens_q[n0], 12);
    chk(lens_q[n0+1] == 6, "R7 second frame length", lens_q[n0+1], 6);

    // R8: over-long block closed at the limit, with output back-pressure
    n0 = lens_q.size();
    ordy_mode = 1;
    send_block(20, 'h600);
    idle(70);
    ordy_mode = 0;
    idle(2);
    chk(lens_q.size() == n0 + 2, "R8 frame count", lens_q.size(), n0 + 2);
    chk(lens_q[n0] == 16, "R8 forced block frame", lens_q[n0], 16);
    chk(lens_q[n0+1] == 4, "R8 remainder frame", lens_q[n0+1], 4);

    // R11: flush memory and threshold together give one frame
    n0 = lens_q.size();
    ordy_mode = 2;
    idle(1);
    send_block(1, 'h700);
    pulse_flush(fc);
    send_block(7, 'h710);
    send_block(7, 'h720);
    pulse_flush(fc);
    ordy_mode = 0;
    idle(25);
    chk(lens_q.size() == n0 + 2, "R11 frame count", lens_q.size(), n0 + 2);
    chk(lens_q[n0+1] == 14, "R11 combined frame length", lens_q[n0+1], 14);
    send_block(2, 'h730);
    d = last_drive;
    idle(40);
    chk(sof_q[$] == d + TO + 2, "R11 flags cleared", sof_q[$], d + TO + 2);

    // R9 and R1: sequence numbers
    chk(seq_q[0] == 0, "R1 first sequence", seq_q[0], 0);
    foreach (seq_q[i]) chk(seq_q[i] == i, "R9 sequence step", seq_q[i], i);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule